// File: doc/BRIEF.md
# Beam Pointing Selector with Neighbourhood Search

This controller chooses which entry of a precomputed beam-weight table feeds the combining datapath for one satellite at a time. A request carries two angle indices taken from prior orbit knowledge. The controller points the table address at that pair and waits for one verdict from the downstream tracking check. A good verdict ends the request at once, and the prior pointing is kept.

A bad verdict sends the controller to check whether the satellite has already set. If it has, the controller gives up on that satellite and signals the stop. If it has not, the controller sweeps a square of neighbouring table cells around the prior pointing. The half-width of the square is programmable. The controller presents one cell at a time and waits for one power report per cell. When the sweep ends, the strongest cell that passed verification becomes the selected beam. If no cell passed, the controller returns to the set-check and may sweep again.

The weight memory, the channel combiner and the power estimator are outside this block. They see only the table address and the strobes.

Top module: `beam_steer_ctrl`

## Requirements
- R1: While reset is held, and at its release, `busy_o`, `done_o` and `stop_o` are 0 and `wt_addr_o` is 0.
- R2: A `start_i` seen while idle latches the prior indices and the half-width. On the next cycle `busy_o` is 1 and `wt_addr_o` equals `{prior_az_i, prior_el_i}`, with azimuth in the upper IDX_W bits and elevation in the lower IDX_W bits.
- R3: During the prior check, a `verify_valid_i` strobe with `verify_ok_i`=1 raises `done_o` for one cycle on the next cycle. At the same time `busy_o` drops to 0 and `wt_addr_o` holds the prior address.
- R4: After a failed prior check, if `transit_i` is 1 on the following cycle, `stop_o` pulses one cycle later. No `done_o` is raised.
- R5: After a failed prior check with `transit_i`=0, the controller sweeps the cells whose offsets from the prior indices run from -N to +N on each axis, N being the latched half-width. Elevation is the inner loop and azimuth the outer loop. Each index wraps modulo 2^IDX_W. `wt_addr_o` shows the current cell, and each `pwr_valid_i` strobe advances the sweep by one cell.
- R6: At the last strobe of a sweep, among the cells whose strobe carried `pwr_ok_i`=1, the one with the largest `pwr_i` is selected. If two such cells have equal power, the earlier one wins. `done_o` pulses on the next cycle and `wt_addr_o` then holds the winning address.
- R7: A sweep in which no strobe carried `pwr_ok_i`=1 raises no pulse. On the next cycle `wt_addr_o` returns to the prior address and the set-check is repeated. That check either stops or starts a new sweep.
- R8: `abort_i` in any state returns the controller to idle on the next cycle with no pulse. `wt_addr_o` keeps the value it had when the abort was seen.
- R9: `start_i` while busy is ignored. The address and the request in progress are unchanged.
- R10: A half-width of 0 sweeps only the prior cell.
- R11: `done_o` and `stop_o` are never both high, each lasts a single cycle, and each occurs only when the bench expects an outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort_i | input | 1 | Synchronous abandon, any state |
| start_i | input | 1 | Begin a request (sampled when idle) |
| prior_az_i | input | IDX_W | Prior azimuth table index |
| prior_el_i | input | IDX_W | Prior elevation table index |
| span_i | input | SPAN_W | Sweep half-width N |
| verify_valid_i | input | 1 | Verdict strobe for the prior beam |
| verify_ok_i | input | 1 | Verdict: prior beam is good |
| transit_i | input | 1 | Satellite has set |
| pwr_valid_i | input | 1 | Power report strobe for the current cell |
| pwr_ok_i | input | 1 | Current cell passed tracking verification |
| pwr_i | input | PWR_W | Measured power of the current cell |
| wt_addr_o | output | 2*IDX_W | Weight table address {azimuth, elevation} |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse: beam selected |
| stop_o | output | 1 | One-cycle pulse: satellite dropped |

## Verification
A corrupted sweep counter shows on `wt_addr_o` at the very next power strobe, because every cell address is compared before its report is driven. A wrong running maximum stays hidden until the sweep ends, and then shows as a wrong address on the `done_o` cycle. The tie and verify-filter patterns are built so that a relaxed comparison or an ignored `pwr_ok_i` picks a different cell. A state that fails to leave a phase shows either as a missing pulse, which leaves the event queue non-empty, or as a stray pulse that finds the queue empty. Either one is visible within one cycle of the expected outcome.

// File: rtl/beam_steer_pkg.sv
// Shared types for the beam pointing selector.
// Assumes: single request in flight; one-hot decoding not required.
package beam_steer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRIOR   = 2'd1,
        ST_TRANSIT = 2'd2,
        ST_SEARCH  = 2'd3
    } steer_state_e;

endpackage

// File: rtl/beam_scan_raster.sv
// Raster offset generator for the neighbourhood sweep.
// Produces signed offsets (a outer, b inner) running -span..+span.
// Assumes: span never changes between load and the last step.
module beam_scan_raster #(
    parameter int SPAN_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  logic [SPAN_W-1:0]   span_i,
    output logic signed [SPAN_W:0] off_a_o,
    output logic signed [SPAN_W:0] off_b_o,
    output logic                last_o
);
    localparam int OFF_W = SPAN_W + 1;

    logic signed [OFF_W-1:0] a_q, b_q, span_s, nspan_s;

    // signed bounds of the sweep
    always_comb begin
        span_s  = $signed({1'b0, span_i});
        nspan_s = -span_s;
    end

    // offset pair: inner axis wraps to -span and carries into the outer axis
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load_i) begin
            a_q <= nspan_s;
            b_q <= nspan_s;
        end else if (step_i) begin
            if (b_q == span_s) begin
                b_q <= nspan_s;
                a_q <= a_q + OFF_W'(1);
            end else begin
                b_q <= b_q + OFF_W'(1);
            end
        end
    end

    assign off_a_o = a_q;
    assign off_b_o = b_q;
    assign last_o  = (a_q == span_s) && (b_q == span_s);
endmodule

// File: rtl/beam_peak_pick.sv
// Running maximum over verified candidates, keeping the first of equals.
// Exposes next-state values so the caller can decide on the final sample.
// Assumes: clear_i precedes the first take_i of each sweep.
module beam_peak_pick #(
    parameter int PWR_W = 16,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             take_i,
    input  logic [PWR_W-1:0] pwr_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             found_nx_o,
    output logic [TAG_W-1:0] tag_nx_o
);
    logic             found_q;
    logic [PWR_W-1:0] pwr_q;
    logic [TAG_W-1:0] tag_q;
    logic             wins;

    // strict comparison keeps the earlier candidate on a tie
    always_comb begin
        wins       = take_i && (!found_q || (pwr_i > pwr_q));
        found_nx_o = found_q || take_i;
        tag_nx_o   = wins ? tag_i : tag_q;
    end

    // best-so-far registers
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            found_q <= 1'b0;
            pwr_q   <= '0;
            tag_q   <= '0;
        end else begin
            found_q <= found_nx_o;
            if (wins) begin
                pwr_q <= pwr_i;
                tag_q <= tag_i;
            end
        end
    end
endmodule

// File: rtl/beam_steer_ctrl.sv
// Two-phase beam pointing selector: prior table pointing, then a
// max-power neighbourhood sweep, abandoned when the satellite has set.
// Assumes: SPAN_W < IDX_W; strobes are single-cycle and arrive only in
// the phase that expects them.
module beam_steer_ctrl
    import beam_steer_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int SPAN_W = 3,
    parameter int PWR_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort_i,
    input  logic               start_i,
    input  logic [IDX_W-1:0]   prior_az_i,
    input  logic [IDX_W-1:0]   prior_el_i,
    input  logic [SPAN_W-1:0]  span_i,
    input  logic               verify_valid_i,
    input  logic               verify_ok_i,
    input  logic               transit_i,
    input  logic               pwr_valid_i,
    input  logic               pwr_ok_i,
    input  logic [PWR_W-1:0]   pwr_i,
    output logic [2*IDX_W-1:0] wt_addr_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               stop_o
);
    localparam int ADDR_W = 2 * IDX_W;
    localparam int OFF_W  = SPAN_W + 1;
    localparam int N_AX   = 2;

    steer_state_e            state_q;
    logic [IDX_W-1:0]        ctr_q  [N_AX];
    logic signed [OFF_W-1:0] off_w  [N_AX];
    logic [IDX_W-1:0]        cand_w [N_AX];
    logic [SPAN_W-1:0]       span_q;
    logic [ADDR_W-1:0]       addr_q, cand_addr, best_nx;
    logic                    done_q, stop_q;
    logic                    scan_load, scan_step, scan_last, take, found_nx;

    // per-axis candidate index, wrapping modulo the table size
    for (genvar g = 0; g < N_AX; g++) begin : g_axis
        assign cand_w[g] = ctr_q[g] + IDX_W'(off_w[g]);
    end

    // sweep control strobes
    always_comb begin
        cand_addr = {cand_w[0], cand_w[1]};
        scan_load = (state_q == ST_TRANSIT) && !transit_i && !abort_i;
        scan_step = (state_q == ST_SEARCH) && pwr_valid_i && !scan_last;
        take      = (state_q == ST_SEARCH) && pwr_valid_i && pwr_ok_i;
    end

    beam_scan_raster #(.SPAN_W(SPAN_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (scan_load),
        .step_i  (scan_step),
        .span_i  (span_q),
        .off_a_o (off_w[0]),
        .off_b_o (off_w[1]),
        .last_o  (scan_last)
    );

    beam_peak_pick #(.PWR_W(PWR_W), .TAG_W(ADDR_W)) u_peak (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (scan_load),
        .take_i     (take),
        .pwr_i      (pwr_i),
        .tag_i      (cand_addr),
        .found_nx_o (found_nx),
        .tag_nx_o   (best_nx)
    );

    // phase sequencing, held pointing and outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ctr_q[0] <= '0;
            ctr_q[1] <= '0;
            span_q   <= '0;
            addr_q   <= '0;
            done_q   <= 1'b0;
            stop_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            stop_q <= 1'b0;
            if (abort_i) begin
                state_q <= ST_IDLE;
                if (state_q == ST_SEARCH) addr_q <= cand_addr;
            end else begin
                unique case (state_q)
                    ST_IDLE: if (start_i) begin
                        ctr_q[0] <= prior_az_i;
                        ctr_q[1] <= prior_el_i;
                        span_q   <= span_i;
                        addr_q   <= {prior_az_i, prior_el_i};
                        state_q  <= ST_PRIOR;
                    end
                    ST_PRIOR: if (verify_valid_i) begin
                        if (verify_ok_i) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_TRANSIT;
                        end
                    end
                    ST_TRANSIT: begin
                        if (transit_i) begin
                            stop_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_SEARCH;
                        end
                    end
                    ST_SEARCH: if (pwr_valid_i && scan_last) begin
                        if (found_nx) begin
                            addr_q  <= best_nx;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            addr_q  <= {ctr_q[0], ctr_q[1]};
                            state_q <= ST_TRANSIT;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign wt_addr_o = (state_q == ST_SEARCH) ? cand_addr : addr_q;
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign stop_o    = stop_q;
endmodule

// File: rtl/beam_steer_ctrl_chk.sv
// Port-level temporal checks for beam_steer_ctrl, attached by bind.
// Assumes: same parameters as the bound instance.
module beam_steer_ctrl_chk #(
    parameter int IDX_W  = 6,
    parameter int SPAN_W = 3,
    parameter int PWR_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               abort_i,
    input logic               start_i,
    input logic [IDX_W-1:0]   prior_az_i,
    input logic [IDX_W-1:0]   prior_el_i,
    input logic               transit_i,
    input logic [2*IDX_W-1:0] wt_addr_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               stop_o
);
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && stop_o));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r11_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !abort_i) |=>
            (busy_o && wt_addr_o == $past({prior_az_i, prior_el_i})));

    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r4_stop_after_transit: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> $past(transit_i));

    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !done_o && !stop_o));

    a_r8_abort_holds: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> $stable(wt_addr_o));

    // R1: outputs quiet while reset is applied
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!done_o && !stop_o);
        end
    end
endmodule

bind beam_steer_ctrl beam_steer_ctrl_chk #(
    .IDX_W(IDX_W), .SPAN_W(SPAN_W), .PWR_W(PWR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_i    (abort_i),
    .start_i    (start_i),
    .prior_az_i (prior_az_i),
    .prior_el_i (prior_el_i),
    .transit_i  (transit_i),
    .wt_addr_o  (wt_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .stop_o     (stop_o)
);

// File: tb/beam_steer_ctrl_tb_top.sv
// Scoreboard bench: drivers queue expected outcomes, a monitor pops them.
module beam_steer_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 6;
    localparam int SPAN_W = 3;
    localparam int PWR_W  = 16;
    localparam int ADDR_W = 2 * IDX_W;
    localparam int MASK   = (1 << IDX_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic abort_i = 0, start_i = 0, verify_valid_i = 0, verify_ok_i = 0;
    logic transit_i = 0, pwr_valid_i = 0, pwr_ok_i = 0;
    logic [IDX_W-1:0]  prior_az_i = '0, prior_el_i = '0;
    logic [SPAN_W-1:0] span_i = '0;
    logic [PWR_W-1:0]  pwr_i = '0;
    logic [ADDR_W-1:0] wt_addr_o;
    logic busy_o, done_o, stop_o;

    beam_steer_ctrl #(.IDX_W(IDX_W), .SPAN_W(SPAN_W), .PWR_W(PWR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .start_i(start_i),
        .prior_az_i(prior_az_i), .prior_el_i(prior_el_i), .span_i(span_i),
        .verify_valid_i(verify_valid_i), .verify_ok_i(verify_ok_i),
        .transit_i(transit_i), .pwr_valid_i(pwr_valid_i), .pwr_ok_i(pwr_ok_i),
        .pwr_i(pwr_i), .wt_addr_o(wt_addr_o), .busy_o(busy_o),
        .done_o(done_o), .stop_o(stop_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { bit is_stop; int addr; string req; } ev_t;
    ev_t exp_q[$];
    int  n_chk = 0, n_bad = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int mk(input int az, input int el);
        return ((az & MASK) << IDX_W) | (el & MASK);
    endfunction

    function automatic int pwr_of(input int mode, input int idx);
        case (mode)
            0: return 100 + (idx * 37) % 50;
            1: return (idx == 2 || idx == 5) ? 900 : 100 + idx;
            default: return idx * 10;
        endcase
    endfunction

    function automatic bit ok_of(input int mode, input int idx);
        case (mode)
            2: return 1'b0;
            3: return (idx % 2) == 1;
            default: return 1'b1;
        endcase
    endfunction

    task automatic push(input bit is_stop, input int addr, input string req);
        ev_t e;
        e.is_stop = is_stop; e.addr = addr; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: every outcome pulse must match the oldest expected event
    always @(negedge clk) begin
        if (rst_n && (done_o || stop_o)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R11 unexpected pulse", int'(wt_addr_o), -1);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                chk(stop_o == e.is_stop && done_o == !e.is_stop, {e.req, " kind"},
                    int'(stop_o), int'(e.is_stop));
                chk(int'(wt_addr_o) == e.addr, {e.req, " address"}, int'(wt_addr_o), e.addr);
            end
        end
    end

    task automatic start_sat(input int az, input int el, input int span);
        start_i = 1; prior_az_i = IDX_W'(az); prior_el_i = IDX_W'(el);
        span_i = SPAN_W'(span);
        @(negedge clk);
        start_i = 0;
        chk(busy_o == 1'b1, "R2 busy", int'(busy_o), 1);
        chk(int'(wt_addr_o) == mk(az, el), "R2 prior address", int'(wt_addr_o), mk(az, el));
    endtask

    task automatic verify(input bit ok, input int addr);
        verify_valid_i = 1; verify_ok_i = ok;
        if (ok) push(0, addr, "R3");
        @(negedge clk);
        verify_valid_i = 0; verify_ok_i = 0;
    endtask

    // entered at the negedge where the first cell is shown
    task automatic sweep(input int caz, input int cel, input int span, input int mode);
        int w, n, best, bestp;
        bit found;
        w = 2 * span + 1; n = w * w; found = 0; best = 0; bestp = 0;
        for (int i = 0; i < n; i++) begin
            if (ok_of(mode, i) && (!found || pwr_of(mode, i) > bestp)) begin
                found = 1; best = i; bestp = pwr_of(mode, i);
            end
        end
        if (found)
            push(0, mk(caz - span + best / w, cel - span + best % w), "R6");
        for (int i = 0; i < n; i++) begin
            int ea;
            ea = mk(caz - span + i / w, cel - span + i % w);
            chk(int'(wt_addr_o) == ea, "R5 cell address", int'(wt_addr_o), ea);
            pwr_valid_i = 1; pwr_ok_i = ok_of(mode, i); pwr_i = PWR_W'(pwr_of(mode, i));
            @(negedge clk);
        end
        pwr_valid_i = 0; pwr_ok_i = 0;
    endtask

    task automatic summary();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && stop_o == 0, "R1 reset flags", int'(busy_o), 0);
        chk(wt_addr_o == '0, "R1 reset address", int'(wt_addr_o), 0);
        rst_n = 1;
        @(negedge clk);

        // R3: prior beam accepted
        start_sat(10, 20, 2);
        verify(1, mk(10, 20));
        chk(busy_o == 0, "R3 idle after done", int'(busy_o), 0);

        // R4: failed check, satellite has set
        start_sat(9, 9, 1);
        transit_i = 1;
        push(1, mk(9, 9), "R4");
        verify(0, 0);
        @(negedge clk);
        transit_i = 0;
        chk(busy_o == 0, "R4 idle after stop", int'(busy_o), 0);

        // R5/R6: distinct powers, span 2
        start_sat(30, 40, 2);
        verify(0, 0); @(negedge clk);
        sweep(30, 40, 2, 0);
        chk(busy_o == 0, "R6 idle after sweep", int'(busy_o), 0);

        // R6: tie keeps the earlier cell
        start_sat(15, 16, 1);
        verify(0, 0); @(negedge clk);
        sweep(15, 16, 1, 1);

        // R5 wrap plus R6 verify filter
        start_sat(0, 63, 1);
        verify(0, 0); @(negedge clk);
        sweep(0, 63, 1, 3);

        // R7: empty sweep, re-check, then a new sweep
        start_sat(5, 5, 1);
        verify(0, 0); @(negedge clk);
        sweep(5, 5, 1, 2);
        chk(int'(wt_addr_o) == mk(5, 5) && busy_o, "R7 back to prior", int'(wt_addr_o), mk(5, 5));
        @(negedge clk);
        sweep(5, 5, 1, 0);

        // R7: empty sweep, then satellite gone
        start_sat(7, 7, 1);
        verify(0, 0); @(negedge clk);
        sweep(7, 7, 1, 2);
        chk(int'(wt_addr_o) == mk(7, 7), "R7 prior restored", int'(wt_addr_o), mk(7, 7));
        transit_i = 1;
        push(1, mk(7, 7), "R7");
        @(negedge clk);
        transit_i = 0;

        // R10: zero half-width
        start_sat(40, 50, 0);
        verify(0, 0); @(negedge clk);
        sweep(40, 50, 0, 0);

        // R8: abort mid-sweep
        start_sat(12, 12, 1);
        verify(0, 0); @(negedge clk);
        pwr_valid_i = 1; pwr_ok_i = 1; pwr_i = 16'd500;
        @(negedge clk);
        pwr_valid_i = 0; pwr_ok_i = 0;
        abort_i = 1;
        @(negedge clk);
        abort_i = 0;
        chk(busy_o == 0, "R8 idle after abort", int'(busy_o), 0);
        chk(int'(wt_addr_o) == mk(11, 12), "R8 address held", int'(wt_addr_o), mk(11, 12));

        // R8: abort during prior check
        start_sat(3, 4, 0);
        abort_i = 1;
        @(negedge clk);
        abort_i = 0;
        chk(busy_o == 0 && int'(wt_addr_o) == mk(3, 4), "R8 abort in prior", int'(wt_addr_o), mk(3, 4));

        // R9: start while busy is ignored
        start_sat(20, 21, 0);
        start_i = 1; prior_az_i = 6'd1; prior_el_i = 6'd1;
        @(negedge clk);
        start_i = 0;
        chk(busy_o && int'(wt_addr_o) == mk(20, 21), "R9 ignored start", int'(wt_addr_o), mk(20, 21));
        verify(1, mk(20, 21));

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11 outcomes outstanding", exp_q.size(), 0);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end
endmodule